// File: doc/BRIEF.md
# Bus Parity Checker and Error Reporter

This block guards a multiplexed address/data bus with even parity. Each clock it captures the 32-bit address/data lines and the 4-bit command/byte-enable lines. On the next clock it compares them against the parity bit, which arrives one cycle late. When the bridge itself drives the bus, the block produces that late parity bit together with an enable for the pad.

Two kinds of errors are reported. An address phase with bad parity produces a system-error pulse, and it tells the claim logic not to assert device-select for that cycle. A checked data phase with bad parity produces a data-parity-error pulse. Which data phases are checked depends on the bridge's role: writes are checked when the bridge is the target, and reads are checked when it is the master. Both error pins are active low, and each has its own output enable. A pin is driven low for one clock, then driven high for one clock, and then released. Two bits of the 16-bit command register gate the reporting. Two sticky flags record a detected error and a signalled system error. Each flag is cleared only by writing a one to its clear bit.

Top module: `bus_parity_guard`

## Requirements
- R1: When `drivePar` is high in cycle T, `parOutEn` is high in cycle T+1 and `parOut` makes the count of ones across the AD and CBE values of cycle T plus `parOut` even. When `drivePar` was low in cycle T, `parOutEn` is low in cycle T+1.
- R2: `claimBlock` is high in cycle T+1 exactly when `addrPhase` was high in cycle T and `parIn` in cycle T+1 fails the even-parity check over the AD and CBE values of cycle T.
- R3: After an address parity error is seen in cycle T+1, `serrN` is low with `serrOe` high in cycle T+2, but only if command register bits 6 and 8 are both 1 in cycle T+1. `serrN` is never low at any other time.
- R4: After a low cycle, the error pin is driven high with its enable still on for one cycle, and its enable is off the cycle after that, unless a new error pulse starts. The pin is high with its enable off whenever no pulse is in progress.
- R5: A parity error on a checked data phase in cycle T (detected in T+1) drives `perrN` low with `perrOe` high in cycle T+2, but only if command register bit 6 is 1 in cycle T+1.
- R6: A data phase is checked when `isWrite`=1 and `isMaster`=0 (write as target), or when `isWrite`=0 and `isMaster`=1 (read as master). Parity errors on any other data phase have no effect on `perrN`, `perrOe` or `flagParity`.
- R7: `flagParity` goes to 1 in the cycle after any detected address or checked-data parity error, whatever the command bits. It clears only when `statusClear[0]` is 1, and a new error in the same cycle wins over the clear.
- R8: `flagSerr` goes to 1 in the same cycle that `serrN` goes low. It clears only when `statusClear[1]` is 1, and setting wins over clearing.
- R9: After reset, both enables and `parOutEn` are 0, both pins read 1, `claimBlock` is 0, and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| adIn | input | 32 | Address/data bus as seen at the pads |
| cbeIn | input | 4 | Command/byte-enable lines |
| parIn | input | 1 | Parity bit covering the previous cycle's AD and CBE |
| addrPhase | input | 1 | This cycle is an address phase |
| dataPhase | input | 1 | A data transfer completes this cycle |
| isWrite | input | 1 | Current transaction is a write |
| isMaster | input | 1 | The bridge is the initiator of the current transaction |
| drivePar | input | 1 | The bridge drives AD this cycle and must supply parity next cycle |
| cmdReg | input | 16 | Command register; bit 6 enables parity response, bit 8 enables system error |
| statusClear | input | 2 | Write-one-to-clear: bit 0 clears flagParity, bit 1 clears flagSerr |
| parOut | output | 1 | Generated parity bit |
| parOutEn | output | 1 | Output enable for the parity pad |
| serrN | output | 1 | System-error pin value, active low |
| serrOe | output | 1 | Output enable for the system-error pad |
| perrN | output | 1 | Data-parity-error pin value, active low |
| perrOe | output | 1 | Output enable for the data-parity-error pad |
| claimBlock | output | 1 | Tells the claim logic to withhold device-select |
| flagParity | output | 1 | Sticky: a parity error was detected |
| flagSerr | output | 1 | Sticky: a system error was signalled |

## Verification
The properties assume that phase flags, direction, role and command bits are sampled cleanly at the rising edge. They also assume that `parIn` in any cycle refers to the AD/CBE values of the cycle before. The stimulus respects this: every input changes on the falling edge, and every parity bit is computed from the bus values the bench drove one cycle earlier, then corrupted deliberately with a chosen probability. Command bits are random on each cycle, so the gates are exercised both open and closed. Back-to-back errors arise naturally, so pulses overlap.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

  // Strobes from control to datapath: which checks apply to this cycle.
  typedef struct packed {
    logic chkAddr;
    logic chkData;
    logic genPar;
  } bpgStrobe_t;

  // Result of the one-cycle-late comparison, returned to control.
  typedef struct packed {
    logic addrBad;
    logic dataBad;
  } bpgErr_t;

endpackage

// File: rtl/bpg_pulse_driver.sv
// Shapes a single-cycle fire into low, high, release on an open-drain style pin.
module bpg_pulse_driver (
  input  logic clk,
  input  logic rstN,
  input  logic fire,
  output logic pinN,
  output logic pinOe
);
  logic lowQ;
  logic highQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowQ  <= 1'b0;
      highQ <= 1'b0;
    end else begin
      lowQ  <= fire;
      highQ <= lowQ;
    end
  end

  assign pinN  = ~lowQ;
  assign pinOe = lowQ | highQ;
endmodule

// File: rtl/bpg_datapath.sv
module bpg_datapath
  import bpg_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AD_W-1:0]  adIn,
  input  logic [CBE_W-1:0] cbeIn,
  input  logic             parIn,
  input  bpgStrobe_t       strobe,
  output bpgErr_t          err,
  output logic             parOut,
  output logic             parOutEn
);
  localparam int COVER_W = AD_W + CBE_W;

  logic [COVER_W-1:0] coverQ;
  bpgStrobe_t         strobeQ;
  logic               oddOnes;
  logic               mismatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coverQ  <= '0;
      strobeQ <= '0;
    end else begin
      coverQ  <= {adIn, cbeIn};
      strobeQ <= strobe;
    end
  end

  // Even parity: the parity bit equals the XOR of the covered bits.
  assign oddOnes  = ^coverQ;
  assign mismatch = oddOnes ^ parIn;

  assign parOut   = strobeQ.genPar ? oddOnes : 1'b0;
  assign parOutEn = strobeQ.genPar;

  assign err.addrBad = strobeQ.chkAddr & mismatch;
  assign err.dataBad = strobeQ.chkData & mismatch;
endmodule

// File: rtl/bpg_control.sv
module bpg_control
  import bpg_pkg::*;
#(
  parameter int CMD_W    = 16,
  parameter int PERR_BIT = 6,
  parameter int SERR_BIT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             addrPhase,
  input  logic             dataPhase,
  input  logic             isWrite,
  input  logic             isMaster,
  input  logic             drivePar,
  input  logic [CMD_W-1:0] cmdReg,
  input  logic [1:0]       statusClear,
  input  bpgErr_t          err,
  output bpgStrobe_t       strobe,
  output logic             serrN,
  output logic             serrOe,
  output logic             perrN,
  output logic             perrOe,
  output logic             flagParity,
  output logic             flagSerr
);
  localparam int CLR_PAR  = 0;
  localparam int CLR_SERR = 1;

  logic roleChecks;
  logic parityRespond;
  logic fireSerr;
  logic firePerr;
  logic anyDetect;

  // Target checks write data; master checks read data.
  assign roleChecks = isWrite ? ~isMaster : isMaster;

  always_comb begin
    strobe         = '0;
    strobe.chkAddr = addrPhase;
    strobe.chkData = dataPhase & roleChecks;
    strobe.genPar  = drivePar;
  end

  assign parityRespond = cmdReg[PERR_BIT];
  assign fireSerr      = err.addrBad & parityRespond & cmdReg[SERR_BIT];
  assign firePerr      = err.dataBad & parityRespond;
  assign anyDetect     = err.addrBad | err.dataBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagParity <= 1'b0;
      flagSerr   <= 1'b0;
    end else begin
      flagParity <= anyDetect | (flagParity & ~statusClear[CLR_PAR]);
      flagSerr   <= fireSerr  | (flagSerr   & ~statusClear[CLR_SERR]);
    end
  end

  bpg_pulse_driver u_serrDrv (
    .clk   (clk),
    .rstN  (rstN),
    .fire  (fireSerr),
    .pinN  (serrN),
    .pinOe (serrOe)
  );

  bpg_pulse_driver u_perrDrv (
    .clk   (clk),
    .rstN  (rstN),
    .fire  (firePerr),
    .pinN  (perrN),
    .pinOe (perrOe)
  );
endmodule

// File: rtl/bus_parity_guard.sv
module bus_parity_guard
  import bpg_pkg::*;
#(
  parameter int AD_W     = 32,
  parameter int CBE_W    = 4,
  parameter int CMD_W    = 16,
  parameter int PERR_BIT = 6,
  parameter int SERR_BIT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AD_W-1:0]  adIn,
  input  logic [CBE_W-1:0] cbeIn,
  input  logic             parIn,
  input  logic             addrPhase,
  input  logic             dataPhase,
  input  logic             isWrite,
  input  logic             isMaster,
  input  logic             drivePar,
  input  logic [CMD_W-1:0] cmdReg,
  input  logic [1:0]       statusClear,
  output logic             parOut,
  output logic             parOutEn,
  output logic             serrN,
  output logic             serrOe,
  output logic             perrN,
  output logic             perrOe,
  output logic             claimBlock,
  output logic             flagParity,
  output logic             flagSerr
);
  bpgStrobe_t strobe;
  bpgErr_t    err;

  bpg_control #(
    .CMD_W    (CMD_W),
    .PERR_BIT (PERR_BIT),
    .SERR_BIT (SERR_BIT)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .addrPhase   (addrPhase),
    .dataPhase   (dataPhase),
    .isWrite     (isWrite),
    .isMaster    (isMaster),
    .drivePar    (drivePar),
    .cmdReg      (cmdReg),
    .statusClear (statusClear),
    .err         (err),
    .strobe      (strobe),
    .serrN       (serrN),
    .serrOe      (serrOe),
    .perrN       (perrN),
    .perrOe      (perrOe),
    .flagParity  (flagParity),
    .flagSerr    (flagSerr)
  );

  bpg_datapath #(
    .AD_W  (AD_W),
    .CBE_W (CBE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .adIn     (adIn),
    .cbeIn    (cbeIn),
    .parIn    (parIn),
    .strobe   (strobe),
    .err      (err),
    .parOut   (parOut),
    .parOutEn (parOutEn)
  );

  assign claimBlock = err.addrBad;
endmodule

// File: rtl/bpg_checker.sv
module bpg_checker #(
  parameter int AD_W     = 32,
  parameter int CBE_W    = 4,
  parameter int CMD_W    = 16,
  parameter int PERR_BIT = 6,
  parameter int SERR_BIT = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             addrPhase,
  input logic             drivePar,
  input logic [CMD_W-1:0] cmdReg,
  input logic [1:0]       statusClear,
  input logic             parOutEn,
  input logic             serrN,
  input logic             serrOe,
  input logic             perrN,
  input logic             perrOe,
  input logic             claimBlock,
  input logic             flagParity,
  input logic             flagSerr
);
  p_paren_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    parOutEn |-> $past(drivePar));

  p_claim_after_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    claimBlock |-> $past(addrPhase));

  p_serr_gated_r3: assert property (@(posedge clk) disable iff (!rstN)
    !serrN |-> ($past(cmdReg[PERR_BIT]) && $past(cmdReg[SERR_BIT]) && serrOe));

  p_serr_high_before_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    (serrOe && serrN) |-> $past(!serrN));

  p_serr_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    (serrOe && serrN) |=> (!serrOe || !serrN));

  p_perr_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    !perrN |-> ($past(cmdReg[PERR_BIT]) && perrOe));

  p_perr_high_before_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    (perrOe && perrN) |-> $past(!perrN));

  p_parity_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagParity) |-> $past(statusClear[0]));

  p_serr_flag_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagSerr) |-> !serrN);

  p_serr_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagSerr) |-> $past(statusClear[1]));
endmodule

bind bus_parity_guard bpg_checker #(
  .AD_W     (AD_W),
  .CBE_W    (CBE_W),
  .CMD_W    (CMD_W),
  .PERR_BIT (PERR_BIT),
  .SERR_BIT (SERR_BIT)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .addrPhase   (addrPhase),
  .drivePar    (drivePar),
  .cmdReg      (cmdReg),
  .statusClear (statusClear),
  .parOutEn    (parOutEn),
  .serrN       (serrN),
  .serrOe      (serrOe),
  .perrN       (perrN),
  .perrOe      (perrOe),
  .claimBlock  (claimBlock),
  .flagParity  (flagParity),
  .flagSerr    (flagSerr)
);

// File: tb/bus_parity_guard_test.sv
module bus_parity_guard_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] adIn = '0;
  logic [3:0]  cbeIn = '0;
  logic        parIn = 1'b0;
  logic        addrPhase = 1'b0, dataPhase = 1'b0, isWrite = 1'b0, isMaster = 1'b0, drivePar = 1'b0;
  logic [15:0] cmdReg = '0;
  logic [1:0]  statusClear = '0;
  logic        parOut, parOutEn, serrN, serrOe, perrN, perrOe, claimBlock, flagParity, flagSerr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench-side model state
  logic [31:0] prevAd = '0;
  logic [3:0]  prevCbe = '0;
  logic        prevAddr = 0, prevChk = 0, prevDrive = 0;
  logic        s1 = 0, s2 = 0, p1 = 0, p2 = 0;
  logic        expFlagP = 0, expFlagS = 0;

  bus_parity_guard uut (.*);

  always #5 clk = ~clk;

  function automatic logic evenBit(input logic [31:0] a, input logic [3:0] c);
    return ^{a, c};
  endfunction

  function automatic logic checkedPhase(input logic dp, input logic wr, input logic mst);
    return dp & ((wr & ~mst) | (~wr & mst));
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [31:0] ad, input logic [3:0] cbe, input logic corrupt,
                      input logic ap, input logic dp, input logic wr, input logic mst,
                      input logic drv, input logic [15:0] cmd, input logic [1:0] clr);
    logic pOk, aErr, dErr, fs, fp;
    @(negedge clk);
    pOk = evenBit(prevAd, prevCbe);
    adIn = ad; cbeIn = cbe; parIn = pOk ^ corrupt;
    addrPhase = ap; dataPhase = dp; isWrite = wr; isMaster = mst; drivePar = drv;
    cmdReg = cmd; statusClear = clr;
    #1;
    chk("R1 parOutEn", parOutEn, prevDrive);
    if (prevDrive) chk("R1 parOut", parOut, pOk);
    chk("R2 claimBlock", claimBlock, prevAddr & corrupt);
    chk("R3 serrN", serrN, ~s1);
    chk("R4 serrOe", serrOe, s1 | s2);
    chk("R5 perrN", perrN, ~p1);
    chk("R6 perrOe", perrOe, p1 | p2);
    chk("R7 flagParity", flagParity, expFlagP);
    chk("R8 flagSerr", flagSerr, expFlagS);
    aErr = prevAddr & corrupt;
    dErr = prevChk & corrupt;
    fs = aErr & cmd[6] & cmd[8];
    fp = dErr & cmd[6];
    s2 = s1; s1 = fs; p2 = p1; p1 = fp;
    expFlagP = aErr | dErr | (expFlagP & ~clr[0]);
    expFlagS = fs | (expFlagS & ~clr[1]);
    prevChk = checkedPhase(dp, wr, mst);
    prevAddr = ap; prevAd = ad; prevCbe = cbe; prevDrive = drv;
  endtask

  task automatic idle(input logic [15:0] cmd);
    step(32'h0, 4'h0, 1'b0, 0, 0, 0, 0, 0, cmd, 2'b00);
  endtask

  localparam logic [15:0] EN_BOTH = 16'h0140;
  localparam logic [15:0] EN_PERR = 16'h0040;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R9 reset serrOe", serrOe, 1'b0);
    chk("R9 reset perrOe", perrOe, 1'b0);
    chk("R9 reset parOutEn", parOutEn, 1'b0);
    chk("R9 reset serrN", serrN, 1'b1);
    chk("R9 reset perrN", perrN, 1'b1);
    chk("R9 reset claimBlock", claimBlock, 1'b0);
    chk("R9 reset flagParity", flagParity, 1'b0);
    chk("R9 reset flagSerr", flagSerr, 1'b0);

    // directed: bad address parity with both enables
    step(32'hDEAD_BEEF, 4'h6, 0, 1, 0, 1, 0, 0, EN_BOTH, 2'b00);
    step(32'h1234_5678, 4'hF, 1, 0, 0, 0, 0, 0, EN_BOTH, 2'b00);
    repeat (4) idle(EN_BOTH);
    // bad address parity, system-error bit off
    step(32'hFFFF_0000, 4'h7, 0, 1, 0, 0, 0, 0, EN_PERR, 2'b11);
    step(32'h0, 4'h0, 1, 0, 0, 0, 0, 0, EN_PERR, 2'b00);
    repeat (4) idle(EN_PERR);
    // write as target with bad data parity
    step(32'hA5A5_A5A5, 4'h0, 0, 0, 1, 1, 0, 0, EN_PERR, 2'b01);
    step(32'h0, 4'h0, 1, 0, 0, 0, 0, 0, EN_PERR, 2'b00);
    repeat (4) idle(EN_PERR);
    // read as target: not checked (R6)
    step(32'h0000_0001, 4'h0, 0, 0, 1, 0, 0, 1, EN_BOTH, 2'b01);
    step(32'h0, 4'h0, 1, 0, 0, 0, 0, 0, EN_BOTH, 2'b00);
    repeat (3) idle(EN_BOTH);
    // read as master, bad parity, back to back
    step(32'h8000_0000, 4'h1, 0, 0, 1, 0, 1, 0, EN_BOTH, 2'b00);
    step(32'h7, 4'h2, 1, 0, 1, 0, 1, 0, EN_BOTH, 2'b00);
    step(32'h0, 4'h0, 1, 0, 0, 0, 0, 0, EN_BOTH, 2'b00);
    repeat (4) idle(EN_BOTH);
    // clear flags
    step(32'h0, 4'h0, 0, 0, 0, 0, 0, 0, EN_BOTH, 2'b11);
    repeat (2) idle(EN_BOTH);

    // constrained random
    void'($urandom(32'd20240613));
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] cmd;
      cmd = 16'($urandom);
      if (($urandom % 4) != 0) cmd[6] = 1'b1;
      if (($urandom % 4) != 0) cmd[8] = 1'b1;
      step($urandom, 4'($urandom), ($urandom % 5) == 0,
           ($urandom % 4) == 0, ($urandom % 5) < 2, 1'($urandom), 1'($urandom),
           1'($urandom), cmd, (($urandom % 8) == 0) ? 2'($urandom) : 2'b00);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule